// File: doc/BRIEF.md
# Prioritised Three-Master Bus Arbiter with Fault Monitor

This block shares one downstream bus among three requesting masters: a DMA engine (master 0), a secondary internal bus (master 1) and the processor's internal bus (master 2). Each master holds a request together with an address, a write flag and write data. A fixed-priority choice is made only while the bus is idle. The winner's address and control are captured and presented on a single slave port until the slave signals completion.

A monitor runs alongside the arbiter. Before anything is forwarded, it checks the winning address against a parameterised region map of `NREG` equal regions of `2**RSZ_LOG2` bytes starting at address 0. An address outside the map, or one that falls in a region whose enable bit is low, is refused. Refused accesses never reach the slave, and the master receives an error response. The monitor also counts the cycles of a forwarded transfer. If the slave stays silent for `TIMEOUT_CYC` cycles, the transfer is aborted with an error response.

The first error is kept in a small status register holding the error kind and the failing master's index. This register drives a level interrupt until software writes a one to the clear input.

The controller has three states. `ST_IDLE` waits for requests. `ST_XFER` forwards a transfer. `ST_FAULT` is a one-cycle error response to a refused address. Its transitions are:
- idle to xfer on a request with a good address;
- idle to fault on a request with a bad address;
- xfer to idle on slave completion or on timeout;
- fault to idle unconditionally.

Top module: `busarb_top`

## Requirements
- R1: When several masters request in an idle cycle, master 0 wins over master 1, and master 1 wins over master 2. Requests are only evaluated in `ST_IDLE`, so at least one idle cycle separates two grants.
- R2: At most one bit of `m_gnt` is high. A request accepted in idle cycle t gives a grant from cycle t+1 through the cycle of its response.
- R3: No new request, from any master, changes the grant while a transfer or an error response is in progress.
- R4: In `ST_XFER`, `s_valid` is high and `s_addr`, `s_wr` and `s_wdata` carry the owner's values captured at grant. In a cycle with `s_ready` high, the owner's `m_done` bit pulses and `m_rdata` equals `s_rdata`.
- R5: If `s_ready` is low in each of `TIMEOUT_CYC` (default 768) consecutive transfer cycles, the owner's `m_err` bit is high in the last of them, and `s_valid` is low in the next cycle. `s_ready` in that last cycle is a normal completion.
- R6: An address whose index `addr >> RSZ_LOG2` is `NREG` or more is illegal. It produces no `s_valid`, and the owner gets a one-cycle `m_err` in the cycle after the request. The error code is 1.
- R7: A legal address in a region whose `region_en` bit is 0 is handled like R6, but with error code 2. A timeout has error code 3, and 0 means no error.
- R8: `err_code` and `err_mst` (0, 1 or 2) load on an error only when the status is empty. They appear one cycle after the request for R6/R7 errors, and one cycle after the `m_err` pulse for timeouts. Later errors leave them unchanged.
- R9: `err_clr` high empties the status at the next edge. An error recorded at that same edge is loaded in its place.
- R10: `irq` is high exactly while `err_code` is non-zero.
- R11: During and right after reset, all grants, responses, `s_valid`, `err_code` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| m_req | input | 3 | Request per master |
| m_addr | input | 3*AW | Address per master, master i at bits i*AW |
| m_wr | input | 3 | Write flag per master |
| m_wdata | input | 3*DW | Write data per master, master i at bits i*DW |
| m_gnt | output | 3 | Grant, one-hot or zero |
| m_done | output | 3 | Completion pulse to owner |
| m_err | output | 3 | Error response pulse to owner |
| m_rdata | output | DW | Read data returned to owner |
| s_valid | output | 1 | Transfer presented to slave |
| s_addr | output | AW | Forwarded address |
| s_wr | output | 1 | Forwarded write flag |
| s_wdata | output | DW | Forwarded write data |
| s_ready | input | 1 | Slave completion |
| s_rdata | input | DW | Slave read data |
| region_en | input | NREG | Enable per map region |
| err_clr | input | 1 | Write-one clear of error status |
| err_code | output | 2 | Recorded error kind |
| err_mst | output | 2 | Index of failing master |
| irq | output | 1 | Error interrupt |

## Verification
The bench keeps the default map of four 4 KiB regions and the default widths. It sets `TIMEOUT_CYC` to 12, so a silent slave reaches the abort within a few cycles. Random stall patterns therefore produce many timeouts, mixed with completions on the last allowed cycle. That timeout value also puts the same-cycle race between a timeout and `err_clr` within reach of the random stimulus.

// File: rtl/busarb_pkg.sv
package busarb_pkg;

    localparam int NMST = 3;
    localparam int MIDW = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_XFER  = 2'd1,
        ST_FAULT = 2'd2
    } arb_state_e;

    typedef enum logic [1:0] {
        ERR_NONE     = 2'd0,
        ERR_ILLEGAL  = 2'd1,
        ERR_DISABLED = 2'd2,
        ERR_TIMEOUT  = 2'd3
    } err_code_e;

endpackage

// File: rtl/arb_fixed_pri.sv
module arb_fixed_pri #(
    parameter int N   = 3,
    parameter int IDW = 2
) (
    input  logic [N-1:0]   req,
    output logic [N-1:0]   pick,
    output logic [IDW-1:0] pick_idx,
    output logic           any
);
    logic [N-1:0] blocked;

    assign blocked[0] = 1'b0;
    assign pick[0]    = req[0];

    genvar g;
    generate
        for (g = 1; g < N; g++) begin : g_chain
            assign blocked[g] = blocked[g-1] | req[g-1];
            assign pick[g]    = req[g] & ~blocked[g];
        end
    endgenerate

    assign any = |req;

    always_comb begin
        pick_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) pick_idx = IDW'(i);
        end
    end

    always_comb begin
        assert_top_first_R1: assert (!req[0] || pick[0]);
        assert_pick_single_R1: assert ($onehot0(pick));
    end
endmodule

// File: rtl/arb_region_check.sv
module arb_region_check #(
    parameter int AW       = 16,
    parameter int RSZ_LOG2 = 12,
    parameter int NREG     = 4
) (
    input  logic [AW-1:0]   addr,
    input  logic [NREG-1:0] region_en,
    output logic            illegal,
    output logic            disabled
);
    localparam int IDXW = AW - RSZ_LOG2;
    localparam int RIW  = (NREG > 1) ? $clog2(NREG) : 1;

    logic [IDXW-1:0] idx;
    logic [RIW-1:0]  ridx;

    assign idx      = addr[AW-1:RSZ_LOG2];
    assign ridx     = idx[RIW-1:0];
    assign illegal  = (idx >= IDXW'(NREG));
    assign disabled = !illegal && !region_en[ridx];

    always_comb begin
        assert_err_kind_excl_R6: assert (!(illegal && disabled));
    end
endmodule

// File: rtl/arb_xfer_timer.sv
module arb_xfer_timer #(
    parameter int LIMIT = 768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    assign expire = run && (cnt_q == CW'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt_q <= '0;
        else if (!run || expire)  cnt_q <= '0;
        else                      cnt_q <= cnt_q + 1'b1;
    end

    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(LIMIT));
    assert_expire_in_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !run || (cnt_q == '0));
endmodule

// File: rtl/busarb_top.sv
module busarb_top
    import busarb_pkg::*;
#(
    parameter int AW          = 16,
    parameter int DW          = 32,
    parameter int RSZ_LOG2    = 12,
    parameter int NREG        = 4,
    parameter int TIMEOUT_CYC = 768
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NMST-1:0]     m_req,
    input  logic [NMST*AW-1:0]  m_addr,
    input  logic [NMST-1:0]     m_wr,
    input  logic [NMST*DW-1:0]  m_wdata,
    output logic [NMST-1:0]     m_gnt,
    output logic [NMST-1:0]     m_done,
    output logic [NMST-1:0]     m_err,
    output logic [DW-1:0]       m_rdata,
    output logic                s_valid,
    output logic [AW-1:0]       s_addr,
    output logic                s_wr,
    output logic [DW-1:0]       s_wdata,
    input  logic                s_ready,
    input  logic [DW-1:0]       s_rdata,
    input  logic [NREG-1:0]     region_en,
    input  logic                err_clr,
    output logic [1:0]          err_code,
    output logic [MIDW-1:0]     err_mst,
    output logic                irq
);
    arb_state_e state_q, state_d;

    logic [NMST-1:0] pick;
    logic [MIDW-1:0] pick_idx;
    logic            any_req;
    logic [AW-1:0]   addr_a  [NMST];
    logic [DW-1:0]   wdata_a [NMST];
    logic [AW-1:0]   sel_addr;
    logic            addr_illegal, addr_disabled, addr_bad;
    logic            expire;

    logic [MIDW-1:0] owner_q;
    logic [NMST-1:0] own_oh;
    logic [AW-1:0]   addr_q;
    logic            wr_q;
    logic [DW-1:0]   wdata_q;

    err_code_e       code_q, code_d, new_code;
    logic [MIDW-1:0] mst_q, mst_d, new_mst;
    logic            new_err;

    genvar g;
    generate
        for (g = 0; g < NMST; g++) begin : g_unpack
            assign addr_a[g]  = m_addr[g*AW +: AW];
            assign wdata_a[g] = m_wdata[g*DW +: DW];
        end
    endgenerate

    arb_fixed_pri #(.N(NMST), .IDW(MIDW)) u_pri (
        .req      (m_req),
        .pick     (pick),
        .pick_idx (pick_idx),
        .any      (any_req)
    );

    assign sel_addr = addr_a[pick_idx];

    arb_region_check #(.AW(AW), .RSZ_LOG2(RSZ_LOG2), .NREG(NREG)) u_map (
        .addr      (sel_addr),
        .region_en (region_en),
        .illegal   (addr_illegal),
        .disabled  (addr_disabled)
    );

    assign addr_bad = addr_illegal | addr_disabled;

    arb_xfer_timer #(.LIMIT(TIMEOUT_CYC)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state_q == ST_XFER),
        .expire (expire)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (any_req) state_d = addr_bad ? ST_FAULT : ST_XFER;
            end
            ST_XFER: begin
                if (s_ready || expire) state_d = ST_IDLE;
            end
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // captured owner and transfer fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            owner_q <= '0;
            addr_q  <= '0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
        end else if (state_q == ST_IDLE && any_req) begin
            owner_q <= pick_idx;
            addr_q  <= sel_addr;
            wr_q    <= m_wr[pick_idx];
            wdata_q <= wdata_a[pick_idx];
        end
    end

    assign own_oh = NMST'(1) << owner_q;

    // outputs
    always_comb begin
        m_gnt   = '0;
        m_done  = '0;
        m_err   = '0;
        s_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_XFER: begin
                m_gnt   = own_oh;
                s_valid = 1'b1;
                if (s_ready)     m_done = own_oh;
                else if (expire) m_err  = own_oh;
            end
            ST_FAULT: begin
                m_gnt = own_oh;
                m_err = own_oh;
            end
            default: ;
        endcase
    end

    assign s_addr  = addr_q;
    assign s_wr    = wr_q;
    assign s_wdata = wdata_q;
    assign m_rdata = s_rdata;

    // error classification
    always_comb begin
        new_err  = 1'b0;
        new_code = ERR_NONE;
        new_mst  = '0;
        if (state_q == ST_IDLE && any_req && addr_bad) begin
            new_err  = 1'b1;
            new_code = addr_illegal ? ERR_ILLEGAL : ERR_DISABLED;
            new_mst  = pick_idx;
        end else if (state_q == ST_XFER && !s_ready && expire) begin
            new_err  = 1'b1;
            new_code = ERR_TIMEOUT;
            new_mst  = owner_q;
        end
    end

    always_comb begin
        code_d = err_clr ? ERR_NONE : code_q;
        mst_d  = err_clr ? '0 : mst_q;
        if (code_d == ERR_NONE && new_err) begin
            code_d = new_code;
            mst_d  = new_mst;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= ERR_NONE;
            mst_q  <= '0;
        end else begin
            code_q <= code_d;
            mst_q  <= mst_d;
        end
    end

    assign err_code = code_q;
    assign err_mst  = mst_q;
    assign irq      = (code_q != ERR_NONE);

    assert_one_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(m_gnt));
    assert_grant_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|m_gnt && !(|m_done) && !(|m_err)) |=> (m_gnt == $past(m_gnt)));
    assert_resp_to_owner_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((m_done | m_err) & ~m_gnt) == '0);
    assert_irq_after_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|m_err && !err_clr) |=> irq);
    assert_no_fwd_refused_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_valid && |m_err) |-> $past(!s_valid));
endmodule

// File: tb/sim_busarb_top.sv
`timescale 1ns/100ps
module sim_busarb_top;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int TO = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [2:0]    m_req = '0;
    logic [3*AW-1:0] m_addr = '0;
    logic [2:0]    m_wr = '0;
    logic [3*DW-1:0] m_wdata = '0;
    logic [2:0]    m_gnt, m_done, m_err;
    logic [DW-1:0] m_rdata;
    logic          s_valid, s_wr;
    logic [AW-1:0] s_addr;
    logic [DW-1:0] s_wdata;
    logic          s_ready = 1'b0;
    logic [DW-1:0] s_rdata = '0;
    logic [3:0]    region_en = 4'hF;
    logic          err_clr = 1'b0;
    logic [1:0]    err_code, err_mst;
    logic          irq;

    busarb_top #(.AW(AW), .DW(DW), .RSZ_LOG2(12), .NREG(4), .TIMEOUT_CYC(TO)) u0 (
        .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_addr(m_addr), .m_wr(m_wr),
        .m_wdata(m_wdata), .m_gnt(m_gnt), .m_done(m_done), .m_err(m_err),
        .m_rdata(m_rdata), .s_valid(s_valid), .s_addr(s_addr), .s_wr(s_wr),
        .s_wdata(s_wdata), .s_ready(s_ready), .s_rdata(s_rdata),
        .region_en(region_en), .err_clr(err_clr), .err_code(err_code),
        .err_mst(err_mst), .irq(irq)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // master agents and stimulus controls
    bit            pend [3];
    logic [AW-1:0] paddr [3];
    bit            pwr [3];
    logic [DW-1:0] pwdata [3];
    bit rnd_on = 0;
    int ready_mode = 2;   // 0 random, 1 never, 2 always, 3 on cycle ready_at, 4 rare
    int ready_at = 0;
    bit clr_one = 0;
    int ord [16];
    int nord = 0;
    int n_done = 0;
    int n_err = 0;
    int cyc = 0;

    // reference model
    int mstate = 0;   // 0 idle, 1 transfer, 2 error response
    int mown = 0;
    int mcnt = 0;
    logic [AW-1:0] maddr;
    bit mwr;
    logic [DW-1:0] mwdata;
    logic [1:0] mcode = 0;
    logic [1:0] mmst = 0;

    function automatic int region_kind(input logic [AW-1:0] a, input logic [3:0] en);
        int idx = int'(a >> 12);
        if (idx >= 4) return 1;
        if (!en[idx]) return 2;
        return 0;
    endfunction

    function automatic logic [AW-1:0] rand_addr();
        if ($urandom % 10 == 0) return AW'(16'h4000 + ($urandom % 16'hC000));
        return AW'($urandom % 16'h4000);
    endfunction

    always @(negedge clk) begin
        bit [2:0] eg, ed, ee;
        bit ev;
        bit nerr;
        logic [1:0] ncode, nmst;
        int w;
        int nxt;
        cyc++;
        // stimulus
        if (rnd_on) begin
            for (int i = 0; i < 3; i++) begin
                if (!pend[i] && ($urandom % 4 == 0)) begin
                    pend[i] = 1; paddr[i] = rand_addr();
                    pwr[i] = $urandom % 2; pwdata[i] = $urandom;
                end
            end
            if (cyc % 64 == 0) region_en = 4'($urandom);
            err_clr = ($urandom % 8 == 0);
        end else begin
            err_clr = clr_one;
            clr_one = 0;
        end
        m_req = {pend[2], pend[1], pend[0]};
        m_addr = {paddr[2], paddr[1], paddr[0]};
        m_wr = {pwr[2], pwr[1], pwr[0]};
        m_wdata = {pwdata[2], pwdata[1], pwdata[0]};
        case (ready_mode)
            0: s_ready = ($urandom % 3 == 0);
            1: s_ready = 0;
            2: s_ready = 1;
            3: s_ready = (mstate == 1 && mcnt == ready_at);
            default: s_ready = ($urandom % 16 == 0);
        endcase
        s_rdata = $urandom;
        #1;
        if (!rst_n) begin
            chk(m_gnt == 0 && m_done == 0 && m_err == 0 && !s_valid, "R11 reset outputs",
                {m_gnt, m_done, m_err, s_valid}, 0);
            chk(err_code == 0 && !irq, "R11 reset status", {err_code, irq}, 0);
            mstate = 0; mcode = 0; mmst = 0;
        end else begin
            eg = 0; ed = 0; ee = 0; ev = 0; nerr = 0; ncode = 0; nmst = 0; nxt = mstate;
            case (mstate)
                0: begin
                    w = -1;
                    for (int i = 2; i >= 0; i--) if (pend[i]) w = i;
                    if (w >= 0) begin
                        mown = w; maddr = paddr[w]; mwr = pwr[w]; mwdata = pwdata[w];
                        if (region_kind(paddr[w], region_en) != 0) begin
                            nerr = 1; ncode = 2'(region_kind(paddr[w], region_en)); nmst = 2'(w);
                            nxt = 2;
                        end else begin
                            nxt = 1; mcnt = 1;
                        end
                    end
                end
                1: begin
                    eg[mown] = 1; ev = 1;
                    if (s_ready) begin ed[mown] = 1; nxt = 0; end
                    else if (mcnt == TO) begin
                        ee[mown] = 1; nxt = 0; nerr = 1; ncode = 3; nmst = 2'(mown);
                    end else mcnt++;
                end
                default: begin
                    eg[mown] = 1; ee[mown] = 1; nxt = 0;
                end
            endcase
            chk(m_gnt == eg, "R1/R2/R3 grant", m_gnt, eg);
            chk(s_valid == ev, "R4/R6 s_valid", s_valid, ev);
            chk(m_done == ed, "R4/R5 done", m_done, ed);
            chk(m_err == ee, "R5/R6/R7 error response", m_err, ee);
            if (ev) chk(s_addr == maddr && s_wr == mwr && s_wdata == mwdata, "R4 forwarded fields",
                        {s_addr, s_wr, s_wdata}, {maddr, mwr, mwdata});
            if (ed != 0) chk(m_rdata == s_rdata, "R4 read data", m_rdata, s_rdata);
            chk(err_code == mcode && err_mst == mmst, "R8/R9 status",
                {err_code, err_mst}, {mcode, mmst});
            chk(irq == (mcode != 0), "R10 irq", irq, mcode != 0);
            for (int i = 0; i < 3; i++) begin
                if (ed[i] || ee[i]) begin
                    pend[i] = 0;
                    if (nord < 16) begin ord[nord] = i; nord++; end
                end
                if (ed[i]) n_done++;
                if (ee[i]) n_err++;
            end
            if (err_clr) begin mcode = 0; mmst = 0; end
            if (mcode == 0 && nerr) begin mcode = ncode; mmst = nmst; end
            mstate = nxt;
        end
    end

    task automatic wait_idle();
        for (int k = 0; k < 3000; k++) begin
            @(posedge clk);
            if (!pend[0] && !pend[1] && !pend[2] && mstate == 0) break;
        end
        @(negedge clk); #2;
    endtask

    task automatic issue(input int i, input logic [AW-1:0] a);
        pend[i] = 1; paddr[i] = a; pwr[i] = i[0]; pwdata[i] = 32'hA500 + 32'(i);
    endtask

    initial begin
        int nd0;
        void'($urandom(32'd2024));
        for (int i = 0; i < 3; i++) begin pend[i] = 0; paddr[i] = 0; pwr[i] = 0; pwdata[i] = 0; end
        repeat (4) @(posedge clk);
        rst_n = 1;
        @(posedge clk);

        // R1: all three at once, completion order by priority
        nord = 0;
        issue(2, 16'h3010); issue(1, 16'h2020); issue(0, 16'h0030);
        wait_idle();
        chk(nord == 3 && ord[0] == 0 && ord[1] == 1 && ord[2] == 2, "R1 order",
            {ord[0][3:0], ord[1][3:0], ord[2][3:0]}, 12'h012);

        // R6: illegal address from master 2
        issue(2, 16'h8000);
        wait_idle();
        chk(err_code == 1 && err_mst == 2, "R6 illegal code", {err_code, err_mst}, 4'b0110);
        chk(irq == 1, "R10 irq set", irq, 1);

        // R8: second error leaves status unchanged
        region_en = 4'b1101;
        issue(1, 16'h1234);
        wait_idle();
        chk(err_code == 1 && err_mst == 2, "R8 sticky", {err_code, err_mst}, 4'b0110);

        // R9: clear
        @(posedge clk); clr_one = 1;
        @(posedge clk); @(negedge clk); #2;
        chk(err_code == 0 && !irq, "R9 cleared", {err_code, irq}, 0);

        // R7: disabled region from master 1
        issue(1, 16'h1234);
        wait_idle();
        chk(err_code == 2 && err_mst == 1, "R7 disabled code", {err_code, err_mst}, 4'b1001);
        region_en = 4'hF;
        @(posedge clk); clr_one = 1;
        @(posedge clk);

        // R5: silent slave times out
        ready_mode = 1;
        issue(0, 16'h0100);
        wait_idle();
        chk(err_code == 3 && err_mst == 0, "R5 timeout code", {err_code, err_mst}, 4'b1100);
        @(posedge clk); clr_one = 1;
        @(posedge clk);

        // R5: completion on the last allowed cycle
        ready_mode = 3; ready_at = TO; nd0 = n_done;
        issue(2, 16'h2200);
        wait_idle();
        chk(n_done == nd0 + 1 && err_code == 0, "R5 last-cycle completion",
            {n_done - nd0, err_code}, 1);

        // random phases
        rnd_on = 1; ready_mode = 0;
        repeat (3000) @(posedge clk);
        ready_mode = 4;
        repeat (2000) @(posedge clk);
        rnd_on = 0; ready_mode = 2;
        wait_idle();
        chk(n_err > 10, "R5/R6 error coverage", n_err, 11);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule